// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the serial front end of a 2048-byte, byte-addressed nonvolatile memory with no write delay. A host talks to it over a four-wire SPI link in either clock idle polarity (modes 0 and 3). The engine runs entirely on a fast system clock. It brings the serial clock, the data input and the active-low select through synchroniser chains and works on edges it detects in the synchronised samples. The system clock must run at least four times the serial clock rate, with each serial clock phase lasting at least two system cycles.

Each select window carries exactly one command byte. Two commands set or clear a write-enable flag held by an external protection unit, and two read or write the status byte that this unit holds. The remaining two commands take a two-byte address and then move an unbounded stream of bytes through an 11-bit address counter that wraps at the top of the array. A byte is written to the array on the cycle after its eighth bit arrives, and only if the protection unit says that address may be written. Read data is fetched from a synchronous array port one byte ahead and serialised on falling serial clock edges. The output-enable is high only while read or status data is being returned.

Top module: `spi_mem_cmd_engine`

## Requirements
- R1: Both serial clock polarities at select fall (modes 0 and 3) are accepted. Input bits are taken on rising serial clock edges, most significant bit first, and the first rising edge after select falls carries bit 7 of the command byte.
- R2: Command 0x06 gives one `wel_set` pulse and command 0x04 gives one `wel_clr` pulse, each when the eighth command bit arrives.
- R3: Only the first byte of a select window is decoded. Bytes after 0x06 or 0x04, and every byte after an undefined command code, cause no strobe, and `spi_sdo_oe` stays low until select returns high.
- R4: Commands 0x03 (read) and 0x02 (write) are followed by two address bytes, high byte first. Only the low 11 bits form the start address, and the upper 5 bits are ignored.
- R5: During a write, each data byte is presented on `mem_wdata` at the current address one cycle after its eighth bit. The address then advances by one, and it wraps from 0x7FF to 0x000 without limit.
- R6: During a read, bytes from consecutive wrapping addresses are returned MSB first. Each bit changes after a falling serial clock edge, and the data input is ignored once the address is complete.
- R7: `mem_we` is high only while `mem_wr_ok` is high for the address on `mem_addr`. A refused byte leaves the array unchanged but still advances the address.
- R8: A rising select ends any command in progress, and a partly received byte is discarded without a write.
- R9: `wr_done` pulses once after select rises if at least one array or status byte was committed in that window, and not otherwise.
- R10: Command 0x05 returns `stat_rdata` in every following byte. For command 0x01, the first following byte is presented on `stat_wdata` with `stat_we`, gated by `sr_wr_ok`, and later bytes are ignored.
- R11: `spi_sdo_oe` is high only while read or status data is being shifted out within an active select, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_sel_n | input | 1 | Active-low select from the host |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host, valid while enabled |
| spi_sdo_oe | output | 1 | Output enable for the serial data pad |
| mem_addr | output | ADDR_W | Array address for read or write strobes |
| mem_wdata | output | 8 | Byte to write into the array |
| mem_we | output | 1 | Array write strobe, gated by protection |
| mem_re | output | 1 | Array read strobe, data expected next cycle and held |
| mem_rdata | input | 8 | Array read data |
| mem_wr_ok | input | 1 | Protection answer for the address on `mem_addr` |
| stat_rdata | input | 8 | Current status byte from the protection unit |
| stat_wdata | output | 8 | New status byte |
| stat_we | output | 1 | Status write strobe, gated by `sr_wr_ok` |
| sr_wr_ok | input | 1 | Protection answer for status writes |
| wel_set | output | 1 | Write-enable set pulse |
| wel_clr | output | 1 | Write-enable clear pulse |
| wr_done | output | 1 | Pulse after a window in which something was committed |

## Verification
Several properties are checked on every cycle: the strobes are mutually exclusive, array writes come only from the write data phase, reads come only after an address or read byte, the address wraps at the top, the output-enable is tied to the output phases, the enable pulses follow the command byte, and the completion pulse follows a deselect. Only the bench scenarios can show that the right bytes reach the right addresses under both clock polarities. The same applies to a refused byte leaving the array intact while the stream moves on, a cut-off byte being dropped, and bytes after a finished or unknown command being inert.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] CMD_WEN_SET = 8'h06;
   localparam logic [BYTE_W-1:0] CMD_WEN_CLR = 8'h04;
   localparam logic [BYTE_W-1:0] CMD_STAT_RD = 8'h05;
   localparam logic [BYTE_W-1:0] CMD_STAT_WR = 8'h01;
   localparam logic [BYTE_W-1:0] CMD_MEM_RD  = 8'h03;
   localparam logic [BYTE_W-1:0] CMD_MEM_WR  = 8'h02;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_WDATA,
      ST_RDATA,
      ST_STRD,
      ST_STWR,
      ST_IDLE
   } eng_st_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic sel_n_i,
   input  logic sdi_i,
   output logic sck_rise,
   output logic sck_fall,
   output logic sel_act,
   output logic sel_start,
   output logic sel_end,
   output logic sdi_s
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_edge_sync: STAGES must be at least 2");
   end

   // bundle bit 2 = sck, bit 1 = sel_n, bit 0 = sdi
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [2:0] q;
      if (g == 0) begin : g_in
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 3'b010;
            else        q <= {sck_i, sel_n_i, sdi_i};
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 3'b010;
            else        q <= g_stage[g-1].q;
         end
      end
   end

   logic [2:0] cur;
   logic       sck_p, sel_p;
   assign cur = g_stage[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p <= 1'b0;
         sel_p <= 1'b1;
      end else begin
         sck_p <= cur[2];
         sel_p <= cur[1];
      end
   end

   assign sel_act   = ~cur[1];
   assign sel_start = ~cur[1] & sel_p;
   assign sel_end   = cur[1] & ~sel_p;
   assign sck_rise  = cur[2] & ~sck_p & sel_act;
   assign sck_fall  = ~cur[2] & sck_p & sel_act;
   assign sdi_s     = cur[0];

   p_edge_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(sck_rise && sck_fall));
   p_sel_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_start && sel_end));
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         sample,
   input  logic         sdi,
   output logic         byte_done,
   output logic [W-1:0] byte_val
);
   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   if (W < 2) begin : g_bad_w
      $error("spi_rx_shifter: W must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [W-1:0]  sh_q;

   assign byte_val  = {sh_q[W-2:0], sdi};
   assign byte_done = sample && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (sample) begin
         sh_q  <= byte_val;
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   p_cnt_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> (cnt_q == '0));
   p_clr_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
endmodule

// File: rtl/spi_tx_serializer.sv
module spi_tx_serializer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift,
   input  logic [W-1:0] src,
   output logic         sdo,
   output logic         oe
);
   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] cnt_q;
   logic [W-1:0]  sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
         sdo   <= 1'b0;
         oe    <= 1'b0;
      end else if (clr) begin
         cnt_q <= '0;
         sdo   <= 1'b0;
         oe    <= 1'b0;
      end else if (shift) begin
         oe <= 1'b1;
         if (cnt_q == '0) begin
            sdo  <= src[W-1];
            sh_q <= {src[W-2:0], 1'b0};
         end else begin
            sdo  <= sh_q[W-1];
            sh_q <= {sh_q[W-2:0], 1'b0};
         end
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   p_oe_needs_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(shift));
   p_idle_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> (cnt_q == '0));
endmodule

// File: rtl/spi_mem_cmd_engine.sv
module spi_mem_cmd_engine
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int ADDR_BYTES  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_sel_n,
   input  logic              spi_sdi,
   output logic              spi_sdo,
   output logic              spi_sdo_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_wr_ok,
   input  logic [7:0]        stat_rdata,
   output logic [7:0]        stat_wdata,
   output logic              stat_we,
   input  logic              sr_wr_ok,
   output logic              wel_set,
   output logic              wel_clr,
   output logic              wr_done
);
   localparam int ACC_W = BYTE_W * ADDR_BYTES;
   localparam int ABC_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam logic [ABC_W-1:0]  AB_LAST  = ABC_W'(ADDR_BYTES - 1);
   localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

   if (ADDR_BYTES < 1) begin : g_bad_ab
      $error("spi_mem_cmd_engine: ADDR_BYTES must be at least 1");
   end
   if (ADDR_W > ACC_W) begin : g_bad_aw
      $error("spi_mem_cmd_engine: ADDR_W exceeds the address bytes");
   end

   logic sck_rise, sck_fall, sel_act, sel_start, sel_end, sdi_s;
   logic byte_done;
   logic [BYTE_W-1:0] rx_byte;

   spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .sck_i(spi_sck), .sel_n_i(spi_sel_n), .sdi_i(spi_sdi),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .sel_act(sel_act),
      .sel_start(sel_start), .sel_end(sel_end), .sdi_s(sdi_s)
   );

   spi_rx_shifter #(.W(BYTE_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(!sel_act), .sample(sck_rise),
      .sdi(sdi_s), .byte_done(byte_done), .byte_val(rx_byte)
   );

   eng_st_e           st_q;
   logic [ABC_W-1:0]  ab_q;
   logic [ACC_W-1:0]  acc_q, acc_nxt;
   logic [ADDR_W-1:0] addr_q, start_addr;
   logic              rd_cmd_q, we_req_q, swr_req_q, committed_q;
   logic              out_phase;
   logic [BYTE_W-1:0] tx_src;

   if (ADDR_BYTES == 1) begin : g_acc_one
      assign acc_nxt = rx_byte;
   end else begin : g_acc_multi
      assign acc_nxt = {acc_q[ACC_W-BYTE_W-1:0], rx_byte};
   end
   assign start_addr = acc_nxt[ADDR_W-1:0];

   assign out_phase = (st_q == ST_RDATA) || (st_q == ST_STRD);
   assign tx_src    = (st_q == ST_STRD) ? stat_rdata : mem_rdata;
   assign mem_we    = we_req_q & mem_wr_ok;
   assign stat_we   = swr_req_q & sr_wr_ok;

   spi_tx_serializer #(.W(BYTE_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(!sel_act),
      .shift(sck_fall && out_phase), .src(tx_src),
      .sdo(spi_sdo), .oe(spi_sdo_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_CMD;
         ab_q        <= '0;
         acc_q       <= '0;
         addr_q      <= '0;
         rd_cmd_q    <= 1'b0;
         we_req_q    <= 1'b0;
         swr_req_q   <= 1'b0;
         committed_q <= 1'b0;
         mem_addr    <= '0;
         mem_wdata   <= '0;
         mem_re      <= 1'b0;
         stat_wdata  <= '0;
         wel_set     <= 1'b0;
         wel_clr     <= 1'b0;
         wr_done     <= 1'b0;
      end else begin
         we_req_q  <= 1'b0;
         swr_req_q <= 1'b0;
         mem_re    <= 1'b0;
         wel_set   <= 1'b0;
         wel_clr   <= 1'b0;
         wr_done   <= 1'b0;

         if (sel_end) begin
            wr_done     <= committed_q;
            committed_q <= 1'b0;
         end else if (mem_we || stat_we) begin
            committed_q <= 1'b1;
         end

         if (!sel_act) begin
            st_q <= ST_CMD;
            ab_q <= '0;
         end else if (byte_done) begin
            unique case (st_q)
               ST_CMD: begin
                  unique case (rx_byte)
                     CMD_WEN_SET: begin wel_set <= 1'b1; st_q <= ST_IDLE; end
                     CMD_WEN_CLR: begin wel_clr <= 1'b1; st_q <= ST_IDLE; end
                     CMD_STAT_RD: st_q <= ST_STRD;
                     CMD_STAT_WR: st_q <= ST_STWR;
                     CMD_MEM_RD:  begin rd_cmd_q <= 1'b1; st_q <= ST_ADDR; end
                     CMD_MEM_WR:  begin rd_cmd_q <= 1'b0; st_q <= ST_ADDR; end
                     default:     st_q <= ST_IDLE;
                  endcase
               end
               ST_ADDR: begin
                  acc_q <= acc_nxt;
                  if (ab_q == AB_LAST) begin
                     if (rd_cmd_q) begin
                        mem_re   <= 1'b1;
                        mem_addr <= start_addr;
                        addr_q   <= start_addr + 1'b1;
                        st_q     <= ST_RDATA;
                     end else begin
                        addr_q <= start_addr;
                        st_q   <= ST_WDATA;
                     end
                  end else begin
                     ab_q <= ab_q + 1'b1;
                  end
               end
               ST_WDATA: begin
                  we_req_q  <= 1'b1;
                  mem_addr  <= addr_q;
                  mem_wdata <= rx_byte;
                  addr_q    <= addr_q + 1'b1;
               end
               ST_RDATA: begin
                  mem_re   <= 1'b1;
                  mem_addr <= addr_q;
                  addr_q   <= addr_q + 1'b1;
               end
               ST_STWR: begin
                  swr_req_q  <= 1'b1;
                  stat_wdata <= rx_byte;
                  st_q       <= ST_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, mem_re, stat_we, wel_set, wel_clr}));
   p_we_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(st_q) == ST_WDATA));
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && sel_act && st_q == ST_WDATA && addr_q == ADDR_TOP)
      |=> (mem_addr == ADDR_TOP && addr_q == '0));
   p_re_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> ($past(st_q) == ST_ADDR || $past(st_q) == ST_RDATA));
   p_wel_from_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wel_set || wel_clr) |-> ($past(st_q) == ST_CMD));
   p_oe_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sdo_oe |-> out_phase);
   p_done_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> !sel_act);
endmodule

// File: tb/tb_spi_mem_cmd_engine.sv
module tb_spi_mem_cmd_engine;
   localparam int AW = 11;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, sck, sel_n, sdi;
   logic sdo, sdo_oe, mem_we, mem_re, stat_we, sr_ok;
   logic wel_set, wel_clr, wr_done, mem_wr_ok;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata, stat_q, stat_wdata;

   logic [7:0] arr   [DEPTH];
   logic [7:0] ref_m [DEPTH];
   logic [7:0] buf_d [16];
   int prot_lim;
   int errs = 0, chks = 0;
   int n_we = 0, n_re = 0, n_sw = 0, n_set = 0, n_clr = 0, n_done = 0;

   spi_mem_cmd_engine dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_sel_n(sel_n), .spi_sdi(sdi),
      .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .mem_wr_ok(mem_wr_ok), .stat_rdata(stat_q),
      .stat_wdata(stat_wdata), .stat_we(stat_we), .sr_wr_ok(sr_ok),
      .wel_set(wel_set), .wel_clr(wel_clr), .wr_done(wr_done)
   );

   assign mem_wr_ok = (int'(mem_addr) < prot_lim);

   always @(posedge clk) begin
      if (mem_we) arr[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= arr[mem_addr];
      if (stat_we) stat_q <= stat_wdata;
      if (rst_n) begin
         n_we   <= n_we + int'(mem_we);
         n_re   <= n_re + int'(mem_re);
         n_sw   <= n_sw + int'(stat_we);
         n_set  <= n_set + int'(wel_set);
         n_clr  <= n_clr + int'(wel_clr);
         n_done <= n_done + int'(wr_done);
      end
   end

   function automatic int wrap_addr(input int a, input int i);
      return (a + i) % DEPTH;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      chks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (8) @(negedge clk);
   endtask

   task automatic begin_tx(input bit m3);
      sck = m3;
      half();
      sel_n = 1'b0;
      half();
   endtask

   task automatic end_tx(input bit m3);
      if (!m3) begin sck = 1'b0; half(); end
      sel_n = 1'b1;
      half(); half(); half();
   endtask

   task automatic xfer(input logic [7:0] mo, output logic [7:0] mi, inout bit oe_any);
      for (int i = 7; i >= 0; i--) begin
         sck = 1'b0;
         sdi = mo[i];
         half();
         mi[i] = sdo;
         oe_any |= sdo_oe;
         sck = 1'b1;
         half();
      end
   endtask

   task automatic do_write(input bit m3, input logic [15:0] a16, input int n);
      logic [7:0] mi;
      bit oe_any = 1'b0;
      int a = int'(a16[AW-1:0]);
      begin_tx(m3);
      xfer(8'h02, mi, oe_any);
      xfer(a16[15:8], mi, oe_any);
      xfer(a16[7:0], mi, oe_any);
      for (int i = 0; i < n; i++) begin
         xfer(buf_d[i], mi, oe_any);
         if (wrap_addr(a, i) < prot_lim) ref_m[wrap_addr(a, i)] = buf_d[i];
      end
      end_tx(m3);
      chk(!oe_any, "R11 oe during write", int'(oe_any), 0);
   endtask

   task automatic do_read(input bit m3, input logic [15:0] a16, input int n, input string req);
      logic [7:0] mi;
      bit oe_any = 1'b0;
      int a = int'(a16[AW-1:0]);
      begin_tx(m3);
      xfer(8'h03, mi, oe_any);
      xfer(a16[15:8], mi, oe_any);
      xfer(a16[7:0], mi, oe_any);
      chk(!oe_any, "R11 oe before read data", int'(oe_any), 0);
      for (int i = 0; i < n; i++) begin
         oe_any = 1'b0;
         xfer(8'($urandom), mi, oe_any);
         chk(mi == ref_m[wrap_addr(a, i)], req, int'(mi), int'(ref_m[wrap_addr(a, i)]));
         chk(oe_any, "R11 oe during read data", int'(oe_any), 1);
      end
      end_tx(m3);
   endtask

   task automatic cmd_bytes(input bit m3, input logic [7:0] b0, input int extra, output bit oe_any);
      logic [7:0] mi;
      oe_any = 1'b0;
      begin_tx(m3);
      xfer(b0, mi, oe_any);
      for (int i = 0; i < extra; i++) xfer(8'(8'h02 + i), mi, oe_any);
      end_tx(m3);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      chks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end

   initial begin
      int we0, set0, clr0, done0, sw0;
      bit oe_any;
      logic [7:0] mi;
      void'($urandom(32'h5A17));
      for (int i = 0; i < DEPTH; i++) begin
         arr[i] = 8'(i * 7 + 3);
         ref_m[i] = 8'(i * 7 + 3);
      end
      prot_lim = DEPTH;
      sr_ok = 1'b1;
      stat_q = 8'h00;
      mem_rdata = 8'h00;
      rst_n = 1'b0; sck = 1'b0; sel_n = 1'b1; sdi = 1'b0;
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R11 reset state
      chk(sdo_oe == 1'b0, "R11 reset oe", int'(sdo_oe), 0);
      chk(mem_we == 1'b0 && n_we == 0, "R5 reset no write", n_we, 0);

      // R2 / R3 enable commands, extra bytes inert (R1 mode 0 and mode 3)
      set0 = n_set; we0 = n_we;
      cmd_bytes(1'b0, 8'h06, 3, oe_any);
      chk(n_set - set0 == 1, "R2 wel_set once", n_set - set0, 1);
      chk(n_we == we0 && !oe_any, "R3 bytes after 0x06 inert", n_we - we0, 0);
      clr0 = n_clr;
      cmd_bytes(1'b1, 8'h04, 2, oe_any);
      chk(n_clr - clr0 == 1, "R2 R1 wel_clr once in mode 3", n_clr - clr0, 1);

      // R3 undefined command followed by command-like bytes
      we0 = n_we; set0 = n_set; clr0 = n_clr; sw0 = n_sw;
      cmd_bytes(1'b0, 8'hA5, 4, oe_any);
      chk((n_we + n_set + n_clr + n_sw) == (we0 + set0 + clr0 + sw0) && !oe_any,
          "R3 undefined command inert", n_we + n_set + n_clr + n_sw, we0 + set0 + clr0 + sw0);

      // R4 upper address bits ignored; R1 read back in the other mode
      for (int i = 0; i < 3; i++) buf_d[i] = 8'(8'hC1 + 8'h11 * i);
      do_write(1'b0, 16'hF810, 3);
      chk(arr[11'h010] == 8'hC1, "R4 byte landed at 0x010", int'(arr[11'h010]), 8'hC1);
      do_read(1'b1, 16'h2010, 3, "R4 R1 read back after masked address");

      // R5 / R6 wrap at the top
      done0 = n_done;
      for (int i = 0; i < 4; i++) buf_d[i] = 8'(8'h5A ^ (8'h1F * i));
      do_write(1'b1, 16'h07FE, 4);
      chk(arr[0] == buf_d[2] && arr[1] == buf_d[3], "R5 wrap to 0x000", int'(arr[0]), int'(buf_d[2]));
      chk(n_done - done0 == 1, "R9 done after committed write", n_done - done0, 1);
      do_read(1'b0, 16'h07FD, 6, "R6 sequential read across wrap");

      // R7 protection: refused bytes still advance the address
      prot_lim = 16'h400;
      we0 = n_we;
      for (int i = 0; i < 4; i++) buf_d[i] = 8'(8'h90 + i);
      do_write(1'b0, 16'h03FE, 4);
      chk(n_we - we0 == 2, "R7 only allowed bytes written", n_we - we0, 2);
      chk(arr[11'h400] == 8'(11'h400 * 7 + 3), "R7 protected byte unchanged",
          int'(arr[11'h400]), int'(8'(11'h400 * 7 + 3)));
      do_read(1'b1, 16'h03FE, 4, "R7 read after partly refused write");
      prot_lim = 0;
      done0 = n_done;
      do_write(1'b0, 16'h0200, 2);
      chk(n_done == done0, "R9 no done when nothing committed", n_done - done0, 0);
      prot_lim = DEPTH;

      // R8 partial byte discarded at deselect
      we0 = n_we;
      oe_any = 1'b0;
      begin_tx(1'b0);
      xfer(8'h02, mi, oe_any); xfer(8'h01, mi, oe_any); xfer(8'h00, mi, oe_any);
      xfer(8'h3C, mi, oe_any);
      ref_m[11'h100] = 8'h3C;
      for (int i = 0; i < 5; i++) begin
         sck = 1'b0; sdi = 1'b1; half(); sck = 1'b1; half();
      end
      end_tx(1'b0);
      chk(n_we - we0 == 1, "R8 partial byte not written", n_we - we0, 1);
      chk(arr[11'h101] == ref_m[11'h101], "R8 next address untouched",
          int'(arr[11'h101]), int'(ref_m[11'h101]));

      // R10 status read and write
      stat_q = 8'h8C;
      begin_tx(1'b1);
      xfer(8'h05, mi, oe_any);
      for (int i = 0; i < 2; i++) begin
         xfer(8'hFF, mi, oe_any);
         chk(mi == 8'h8C, "R10 status byte returned", int'(mi), 8'h8C);
      end
      end_tx(1'b1);
      sw0 = n_sw; done0 = n_done;
      begin_tx(1'b0);
      xfer(8'h01, mi, oe_any); xfer(8'h3A, mi, oe_any); xfer(8'hFF, mi, oe_any);
      end_tx(1'b0);
      chk(stat_q == 8'h3A && n_sw - sw0 == 1, "R10 status written once", int'(stat_q), 8'h3A);
      chk(n_done - done0 == 1, "R9 done after status write", n_done - done0, 1);
      sr_ok = 1'b0;
      begin_tx(1'b1);
      xfer(8'h01, mi, oe_any); xfer(8'h55, mi, oe_any);
      end_tx(1'b1);
      chk(stat_q == 8'h3A, "R10 refused status write", int'(stat_q), 8'h3A);
      sr_ok = 1'b1;

      // random traffic, R5 R6 under both modes
      for (int k = 0; k < 24; k++) begin
         bit m3 = 1'($urandom);
         logic [15:0] a16 = 16'($urandom);
         int n = 1 + int'($urandom % 5);
         if ($urandom % 2 == 0) begin
            for (int i = 0; i < n; i++) buf_d[i] = 8'($urandom);
            do_write(m3, a16, n);
         end
         do_read(~m3, a16, n, "R6 R5 random read back");
      end

      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end
endmodule